// File: doc/BRIEF.md
# Receive Character Queue with Fill Threshold

This block sits between a serial receiver's shift register and the CPU's read path for one channel. Each time the receiver completes a character it presents the byte and three error flags: parity, framing and break. The block queues up to sixteen such characters, each with its own flags, and shows the oldest one to the CPU. A read strobe removes that oldest character from the queue.

The block also assembles the eight-bit line status word that the CPU reads. It raises a threshold output once the number of stored characters reaches a level chosen by a two-bit field. A single mode input picks between the queued behaviour and a character mode. In character mode the storage shrinks to one holding register, and the queue-only indications stay at zero.

The transmit side supplies two of the status bits, and the block passes them through unchanged. The block reports an overrun when a character arrives and there is no room for it. In that case it keeps the stored characters and drops the new one.

Top module: `rx_fifo_trig`

## Requirements
- R1: After reset the queue is empty, `lineStatus` bits 0 to 4 and bit 7 are 0, and `trigHit` is 0.
- R2: In queued mode (`fifoMode`=1) up to 16 characters are stored. `rdData` shows the oldest one, and each `rdStrobe` removes it, so characters leave in arrival order.
- R3: `lineStatus` bit 0 (data ready) is 1 exactly when at least one character is stored.
- R4: `trigSel` selects the threshold: 00 means 1, 01 means 4, 10 means 8, 11 means 14. In queued mode, `trigHit` is 1 while the stored count is at or above the selected threshold.
- R5: A write (`wrValid`) that arrives when the storage is full, with no read in the same cycle, sets `lineStatus` bit 1 (overrun). The new character is discarded and the stored characters stay unchanged.
- R6: The overrun bit clears in the cycle after a `lsrRead` strobe, unless a new overrun occurs in that same cycle.
- R7: `lineStatus` bit 2 (parity), bit 3 (framing) and bit 4 (break) report the flags stored with the oldest character. They read 0 when the queue is empty.
- R8: In queued mode, `lineStatus` bit 7 is 1 while any stored character carries a parity, framing or break flag. It returns to 0 once the last such character has been removed.
- R9: `lineStatus` bit 5 follows `txHoldEmpty` and bit 6 follows `txEmpty`.
- R10: In character mode (`fifoMode`=0) the storage holds one character, and a second write before a read is an overrun. `trigHit` and `lineStatus` bit 7 read 0.
- R11: A change of `fifoMode` empties the storage. A write in the cycle of the change is ignored.
- R12: A read strobe on an empty queue has no effect. A read and a write in the same cycle on a full queue both take effect, without overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrValid | input | 1 | Receiver has a completed character this cycle |
| wrData | input | 8 | Received character |
| wrParityErr | input | 1 | Parity flag of the received character |
| wrFrameErr | input | 1 | Framing flag of the received character |
| wrBreak | input | 1 | Break flag of the received character |
| rdStrobe | input | 1 | CPU removes the oldest character |
| lsrRead | input | 1 | CPU reads the line status word |
| fifoMode | input | 1 | 1 = queued mode, 0 = character mode |
| trigSel | input | 2 | Threshold select |
| txHoldEmpty | input | 1 | Transmit holding register empty, from the transmit side |
| txEmpty | input | 1 | Transmitter fully empty, from the transmit side |
| rdData | output | 8 | Oldest stored character |
| lineStatus | output | 8 | Line status word |
| trigHit | output | 1 | Stored count at or above threshold |

## Verification
The ordering test fills the queue with distinct bytes and drains it. This separates correct pointer wrap from slot reuse or lost entries. The threshold test steps the count up one character at a time for each of the four selections, which exposes a wrong encoding or an off-by-one compare. The error tests push clean and flagged characters in a mixed sequence, so a head-flag fault can be told apart from a summary-count fault. Full-queue writes with and without a simultaneous read, plus writes in character mode, separate overrun detection from the capacity rule.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int DATA_W = 8;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              parityErr;
    logic              frameErr;
    logic              breakErr;
  } rxEntry_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } rxStrobe_t;

  // Threshold encoding: 00 -> 1, 01 -> 4, 10 -> 8, 11 -> 14
  function automatic int trigLevel(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic entryHasErr(input rxEntry_t e);
    return e.parityErr | e.frameErr | e.breakErr;
  endfunction

endpackage

// File: rtl/rxq_data.sv
module rxq_data
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  rxStrobe_t                  strb,
  input  rxEntry_t                   wrEntry,
  output rxEntry_t                   headEntry,
  output logic [$clog2(DEPTH+1)-1:0] fillCount,
  output logic                       anyErr
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  rxEntry_t          slotQ [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  countQ, errCountQ;
  logic              incErr, decErr;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strb.push) slotQ[wrPtr] <= wrEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= advance(wrPtr);
      if (strb.pop)  rdPtr <= advance(rdPtr);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strb.flush) begin
      countQ <= '0;
    end else begin
      case ({strb.push, strb.pop})
        2'b10:   countQ <= countQ + 1'b1;
        2'b01:   countQ <= countQ - 1'b1;
        default: countQ <= countQ;
      endcase
    end
  end

  assign incErr = strb.push && entryHasErr(wrEntry);
  assign decErr = strb.pop && entryHasErr(slotQ[rdPtr]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCountQ <= '0;
    end else if (strb.flush) begin
      errCountQ <= '0;
    end else begin
      case ({incErr, decErr})
        2'b10:   errCountQ <= errCountQ + 1'b1;
        2'b01:   errCountQ <= errCountQ - 1'b1;
        default: errCountQ <= errCountQ;
      endcase
    end
  end

  always_comb begin
    headEntry = slotQ[rdPtr];
    if (countQ == '0) headEntry = '0;
  end

  assign fillCount = countQ;
  assign anyErr    = (errCountQ != '0);

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrValid,
  input  logic                       rdStrobe,
  input  logic                       lsrRead,
  input  logic                       fifoMode,
  input  logic [$clog2(DEPTH+1)-1:0] fillCount,
  output rxStrobe_t                  strb,
  output logic                       overrun
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             modeQ;
  logic [CNT_W-1:0] capacity;
  logic             isFull, isEmpty, ovrSet;

  assign capacity = fifoMode ? CNT_W'(DEPTH) : CNT_W'(1);
  assign isFull   = (fillCount >= capacity);
  assign isEmpty  = (fillCount == '0);

  always_comb begin
    strb.flush = (modeQ != fifoMode);
    strb.pop   = rdStrobe && !isEmpty && !strb.flush;
    strb.push  = wrValid && !strb.flush && (!isFull || strb.pop);
  end

  assign ovrSet = wrValid && !strb.flush && isFull && !strb.pop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      modeQ <= fifoMode;
      if (ovrSet)       overrun <= 1'b1;
      else if (lsrRead) overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrParityErr,
  input  logic              wrFrameErr,
  input  logic              wrBreak,
  input  logic              rdStrobe,
  input  logic              lsrRead,
  input  logic              fifoMode,
  input  logic [1:0]        trigSel,
  input  logic              txHoldEmpty,
  input  logic              txEmpty,
  output logic [DATA_W-1:0] rdData,
  output logic [7:0]        lineStatus,
  output logic              trigHit
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  rxStrobe_t        strb;
  rxEntry_t         wrEntry, headEntry;
  logic [CNT_W-1:0] fillCount;
  logic             anyErr, overrun;

  assign wrEntry = '{data: wrData, parityErr: wrParityErr,
                     frameErr: wrFrameErr, breakErr: wrBreak};

  rxq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdStrobe(rdStrobe),
    .lsrRead(lsrRead), .fifoMode(fifoMode), .fillCount(fillCount),
    .strb(strb), .overrun(overrun)
  );

  rxq_data #(.DEPTH(DEPTH)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrEntry(wrEntry),
    .headEntry(headEntry), .fillCount(fillCount), .anyErr(anyErr)
  );

  assign rdData  = headEntry.data;
  assign trigHit = fifoMode && (fillCount >= CNT_W'(trigLevel(trigSel)));

  always_comb begin
    lineStatus[0] = (fillCount != '0);
    lineStatus[1] = overrun;
    lineStatus[2] = headEntry.parityErr;
    lineStatus[3] = headEntry.frameErr;
    lineStatus[4] = headEntry.breakErr;
    lineStatus[5] = txHoldEmpty;
    lineStatus[6] = txEmpty;
    lineStatus[7] = fifoMode && anyErr;
  end

endmodule

// File: rtl/rx_fifo_trig_chk.sv
module rx_fifo_trig_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       wrValid,
  input logic                       rdStrobe,
  input logic                       lsrRead,
  input logic                       fifoMode,
  input logic                       flush,
  input logic [$clog2(DEPTH+1)-1:0] fillCount,
  input logic [7:0]                 lineStatus
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));

  assert_ready_after_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !flush) |=> lineStatus[0]);

  assert_overrun_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !rdStrobe && !flush &&
     fillCount == (fifoMode ? CNT_W'(DEPTH) : CNT_W'(1))) |=> lineStatus[1]);

  assert_overrun_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lsrRead && !wrValid) |=> !lineStatus[1]);

  assert_char_capacity_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoMode && !$past(fifoMode)) |-> fillCount <= CNT_W'(1));

  assert_mode_empties_R11: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> fillCount == '0);

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!wrValid && !rdStrobe && !flush) |=> $stable(fillCount));

endmodule

bind rx_fifo_trig rx_fifo_trig_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdStrobe(rdStrobe),
  .lsrRead(lsrRead), .fifoMode(fifoMode), .flush(strb.flush),
  .fillCount(fillCount), .lineStatus(lineStatus)
);

// File: tb/rx_fifo_trig_tb_top.sv
module rx_fifo_trig_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic       wrParityErr = 1'b0, wrFrameErr = 1'b0, wrBreak = 1'b0;
  logic       rdStrobe = 1'b0, lsrRead = 1'b0;
  logic       fifoMode = 1'b1;
  logic [1:0] trigSel = 2'b00;
  logic       txHoldEmpty = 1'b0, txEmpty = 1'b0;
  logic [7:0] rdData, lineStatus;
  logic       trigHit;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5ns clk = ~clk;

  rx_fifo_trig dut_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .wrParityErr(wrParityErr), .wrFrameErr(wrFrameErr), .wrBreak(wrBreak),
    .rdStrobe(rdStrobe), .lsrRead(lsrRead), .fifoMode(fifoMode),
    .trigSel(trigSel), .txHoldEmpty(txHoldEmpty), .txEmpty(txEmpty),
    .rdData(rdData), .lineStatus(lineStatus), .trigHit(trigHit)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d, input logic pe, input logic fe, input logic bi);
    @(negedge clk);
    wrValid = 1'b1; wrData = d; wrParityErr = pe; wrFrameErr = fe; wrBreak = bi;
    @(negedge clk);
    wrValid = 1'b0; wrParityErr = 1'b0; wrFrameErr = 1'b0; wrBreak = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic readStatus();
    @(negedge clk);
    lsrRead = 1'b1;
    @(negedge clk);
    lsrRead = 1'b0;
  endtask

  task automatic setMode(input logic m);
    @(negedge clk);
    fifoMode = m;
    idle(2);
  endtask

  task automatic emptyAll();
    setMode(1'b0);
    setMode(1'b1);
    readStatus();
  endtask

  task automatic testReset();
    chk("R1", "status after reset", int'(lineStatus), 0);
    chk("R1", "trigHit after reset", int'(trigHit), 0);
  endtask

  task automatic testOrder();
    emptyAll();
    chk("R3", "ready when empty", int'(lineStatus[0]), 0);
    for (int i = 0; i < 16; i++) push(8'(i * 7 + 3), 1'b0, 1'b0, 1'b0);
    chk("R3", "ready when filled", int'(lineStatus[0]), 1);
    chk("R2", "no overrun at 16", int'(lineStatus[1]), 0);
    for (int i = 0; i < 16; i++) begin
      chk("R2", "drain order", int'(rdData), (i * 7 + 3) & 8'hFF);
      pop();
    end
    chk("R3", "ready after drain", int'(lineStatus[0]), 0);
  endtask

  task automatic testTrigger();
    int lvl [4] = '{1, 4, 8, 14};
    for (int s = 0; s < 4; s++) begin
      emptyAll();
      trigSel = 2'(s);
      idle(1);
      chk("R4", "trigHit at zero", int'(trigHit), 0);
      for (int k = 1; k <= 14; k++) begin
        push(8'(k), 1'b0, 1'b0, 1'b0);
        chk("R4", $sformatf("trigHit sel %0d count %0d", s, k), int'(trigHit),
            (k >= lvl[s]) ? 1 : 0);
      end
    end
    trigSel = 2'b00;
  endtask

  task automatic testOverrun();
    emptyAll();
    for (int i = 0; i < 16; i++) push(8'(8'h20 + i), 1'b0, 1'b0, 1'b0);
    push(8'hEE, 1'b1, 1'b0, 1'b0);
    chk("R5", "overrun on full write", int'(lineStatus[1]), 1);
    chk("R5", "head kept", int'(rdData), 8'h20);
    idle(3);
    chk("R6", "overrun held until read", int'(lineStatus[1]), 1);
    readStatus();
    chk("R6", "overrun cleared by status read", int'(lineStatus[1]), 0);
    for (int i = 0; i < 16; i++) begin
      chk("R5", "contents kept", int'(rdData), 8'h20 + i);
      pop();
    end
    chk("R5", "dropped char absent", int'(lineStatus[0]), 0);
  endtask

  task automatic testFlags();
    emptyAll();
    push(8'hA0, 1'b0, 1'b0, 1'b0);
    push(8'hA1, 1'b1, 1'b0, 1'b0);
    push(8'hA2, 1'b0, 1'b1, 1'b0);
    push(8'hA3, 1'b0, 1'b0, 1'b1);
    push(8'hA4, 1'b0, 1'b0, 1'b0);
    chk("R7", "clean head flags", int'(lineStatus[4:2]), 0);
    chk("R8", "summary with errored entries", int'(lineStatus[7]), 1);
    pop();
    chk("R7", "parity head bit2", int'(lineStatus[4:2]), 3'b001);
    pop();
    chk("R7", "framing head bit3", int'(lineStatus[4:2]), 3'b010);
    pop();
    chk("R7", "break head bit4", int'(lineStatus[4:2]), 3'b100);
    chk("R8", "summary with one errored left", int'(lineStatus[7]), 1);
    pop();
    chk("R8", "summary after last errored gone", int'(lineStatus[7]), 0);
    chk("R7", "clean tail flags", int'(lineStatus[4:2]), 0);
    pop();
    chk("R7", "flags when empty", int'(lineStatus[4:2]), 0);
  endtask

  task automatic testTx();
    @(negedge clk);
    txHoldEmpty = 1'b1; txEmpty = 1'b0;
    @(negedge clk);
    chk("R9", "bits 6:5 = 01", int'(lineStatus[6:5]), 2'b01);
    txHoldEmpty = 1'b0; txEmpty = 1'b1;
    @(negedge clk);
    chk("R9", "bits 6:5 = 10", int'(lineStatus[6:5]), 2'b10);
    txEmpty = 1'b0;
  endtask

  task automatic testChar();
    setMode(1'b0);
    readStatus();
    trigSel = 2'b00;
    push(8'h11, 1'b0, 1'b0, 1'b0);
    chk("R10", "ready in char mode", int'(lineStatus[0]), 1);
    chk("R10", "trigHit zero in char mode", int'(trigHit), 0);
    push(8'h22, 1'b1, 1'b0, 1'b0);
    chk("R10", "second write overruns", int'(lineStatus[1]), 1);
    chk("R10", "holding register kept", int'(rdData), 8'h11);
    pop();
    chk("R10", "empty after one read", int'(lineStatus[0]), 0);
    readStatus();
    push(8'h33, 1'b1, 1'b0, 1'b0);
    chk("R10", "parity bit shown", int'(lineStatus[2]), 1);
    chk("R10", "summary bit zero", int'(lineStatus[7]), 0);
    pop();
  endtask

  task automatic testModeChange();
    setMode(1'b1);
    push(8'h01, 1'b0, 1'b0, 1'b0);
    push(8'h02, 1'b1, 1'b0, 1'b0);
    push(8'h03, 1'b0, 1'b0, 1'b0);
    setMode(1'b0);
    chk("R11", "emptied on mode change", int'(lineStatus[0]), 0);
    @(negedge clk);
    fifoMode = 1'b1; wrValid = 1'b1; wrData = 8'h5A;
    @(negedge clk);
    wrValid = 1'b0;
    chk("R11", "write in change cycle ignored", int'(lineStatus[0]), 0);
    chk("R11", "summary cleared", int'(lineStatus[7]), 0);
  endtask

  task automatic testEdges();
    emptyAll();
    pop();
    chk("R12", "empty read keeps empty", int'(lineStatus[0]), 0);
    push(8'h05, 1'b0, 1'b0, 1'b0);
    chk("R12", "pointer intact after empty read", int'(rdData), 8'h05);
    pop();
    for (int i = 0; i < 16; i++) push(8'(8'h40 + i), 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rdStrobe = 1'b1; wrValid = 1'b1; wrData = 8'h99;
    @(negedge clk);
    rdStrobe = 1'b0; wrValid = 1'b0;
    chk("R12", "no overrun on read+write full", int'(lineStatus[1]), 0);
    for (int i = 1; i < 16; i++) begin
      chk("R12", "order after read+write", int'(rdData), 8'h40 + i);
      pop();
    end
    chk("R12", "new char stored last", int'(rdData), 8'h99);
    pop();
    chk("R12", "empty at end", int'(lineStatus[0]), 0);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(3);
    testReset();
    testOrder();
    testTrigger();
    testOverrun();
    testFlags();
    testTx();
    testChar();
    testModeChange();
    testEdges();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule